// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block sits beside an integer pipeline. It performs 64 x 64 multiplication and 64-bit division over many cycles, and it keeps the results in its own pair of result registers, HI and LO. It does not return them to a general destination register. A multiply splits its 128-bit product across the pair. A divide puts its quotient in LO and its remainder in HI. The pipeline reads both registers at any time. It can also load either register directly through a move-to write port, which takes effect only while the unit is idle.

Operations arrive on a valid/ready request channel, with `req_ready` equal to the inverse of `busy`. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. A request offered while `req_ready` is low is dropped, not held, so the requester must present it again once the unit is idle. Both multiply and divide work on operand magnitudes, one bit per cycle for 64 cycles. One further cycle then applies the sign correction and commits the result, and a single-cycle `done` pulse follows. Divide by zero raises no exception and gives a fixed result.

Top module: `hilo_muldiv`

## Requirements
- R1: While reset is asserted and in the first cycle after it, HI and LO read zero, `busy` and `done` are low and `req_ready` is high.
- R2: Operation code 2'b00 (signed multiply) treats both operands as two's complement and writes the upper 64 bits of the 128-bit product to HI and the lower 64 bits to LO.
- R3: Operation code 2'b01 (unsigned multiply) treats both operands as unsigned and splits the 128-bit product the same way: upper half to HI, lower half to LO.
- R4: Operation code 2'b10 (signed divide) writes to LO the quotient truncated toward zero, and to HI the remainder, which carries the sign of the dividend. The most negative dividend divided by -1 gives LO = 0x8000_0000_0000_0000 and HI = 0.
- R5: Operation code 2'b11 (unsigned divide) writes the unsigned quotient to LO and the unsigned remainder to HI.
- R6: A divide whose divisor is zero, signed or unsigned, completes normally with LO = all ones and HI = the dividend as presented.
- R7: After a request is accepted, `busy` is high for exactly 65 cycles. HI and LO change at the clock edge that ends those 65 cycles. `done` is high for exactly the one following cycle, and the new HI and LO are readable in that cycle.
- R8: A request offered while `busy` is high is discarded. It does not change the result of the operation in flight and produces no extra `done` pulse.
- R9: While the unit is idle, `hi_wr_en` loads `hi_wr_data` into HI and `lo_wr_en` loads `lo_wr_data` into LO, and the new value is readable in the next cycle. While `busy` is high, both write ports are ignored.
- R10: If a move-to write and an accepted request fall in the same idle cycle, the write takes effect at once. The result of the operation then overwrites it when that operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can take a request (idle) |
| req_op | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| req_a | input | 64 | Multiplicand or dividend |
| req_b | input | 64 | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: HI and LO just updated |
| hi_wr_en | input | 1 | Move-to-HI strobe |
| hi_wr_data | input | 64 | Value for HI |
| lo_wr_en | input | 1 | Move-to-LO strobe |
| lo_wr_data | input | 64 | Value for LO |
| hi | output | 64 | HI register |
| lo | output | 64 | LO register |

## Verification
Two functions can fall in the same cycle: a move-to write and the acceptance of a new request, both on an idle cycle. The bench provokes this by driving a write strobe and `req_valid` on the same cycle. It then judges that HI shows the written value on the next cycle and holds the computed result once `done` rises. It also offers a request and write strobes in the middle of a busy period. It judges that neither disturbs the in-flight result or produces an extra `done`.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [1:0] {
    OP_MUL  = 2'b00,
    OP_MULU = 2'b01,
    OP_DIV  = 2'b10,
    OP_DIVU = 2'b11
  } mdu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIX  = 2'b10
  } mdu_state_e;
endpackage

// File: rtl/mdu_prep.sv
module mdu_prep #(
  parameter int W = 64
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] a_mag,
  output logic [W-1:0] b_mag,
  output logic         is_div,
  output logic         div_zero,
  output logic         neg_main,
  output logic         neg_rem
);
  logic sa, sb;

  always_comb begin
    is_div   = op[1];
    sa       = ~op[0] & a[W-1];
    sb       = ~op[0] & b[W-1];
    a_mag    = sa ? (~a + 1'b1) : a;
    b_mag    = sb ? (~b + 1'b1) : b;
    div_zero = op[1] & (b == '0);
    neg_main = sa ^ sb;
    neg_rem  = sa;
  end
endmodule

// File: rtl/mdu_engine.sv
module mdu_engine
  import mdu_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         is_div,
  input  logic [W-1:0] a_mag,
  input  logic [W-1:0] b_mag,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] raw_hi,
  output logic [W-1:0] raw_lo
);
  localparam int CW = $clog2(W);

  mdu_state_e       state;
  logic [CW-1:0]    cnt;
  logic             div_q;
  logic [W:0]       acc;
  logic [W-1:0]     sh;
  logic [W-1:0]     opnd;

  logic [W:0]       mul_sum;
  logic [W:0]       rem_sh;
  logic [W+1:0]     diff;
  logic [W:0]       acc_nx;
  logic [W-1:0]     sh_nx;

  always_comb begin
    mul_sum = {1'b0, acc[W-1:0]} + (sh[0] ? {1'b0, opnd} : '0);
    rem_sh  = {acc[W-1:0], sh[W-1]};
    diff    = {1'b0, rem_sh} - {2'b00, opnd};
    if (div_q) begin
      if (!diff[W+1]) begin
        acc_nx = diff[W:0];
        sh_nx  = {sh[W-2:0], 1'b1};
      end else begin
        acc_nx = rem_sh;
        sh_nx  = {sh[W-2:0], 1'b0};
      end
    end else begin
      acc_nx = {1'b0, mul_sum[W:1]};
      sh_nx  = {mul_sum[0], sh[W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      div_q <= 1'b0;
      acc   <= '0;
      sh    <= '0;
      opnd  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_RUN;
          cnt   <= '0;
          div_q <= is_div;
          acc   <= '0;
          sh    <= is_div ? a_mag : b_mag;
          opnd  <= is_div ? b_mag : a_mag;
        end
        ST_RUN: begin
          acc <= acc_nx;
          sh  <= sh_nx;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(W - 1)) state <= ST_FIX;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state != ST_IDLE);
  assign fin    = (state == ST_FIX);
  assign raw_hi = acc[W-1:0];
  assign raw_lo = sh;
endmodule

// File: rtl/mdu_fix.sv
module mdu_fix #(
  parameter int W = 64
) (
  input  logic         is_div,
  input  logic         div_zero,
  input  logic         neg_main,
  input  logic         neg_rem,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] raw_hi,
  input  logic [W-1:0] raw_lo,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo
);
  logic [2*W-1:0] prod;

  always_comb begin
    prod = {raw_hi, raw_lo};
    if (neg_main) prod = ~prod + 1'b1;
    if (!is_div) begin
      res_hi = prod[2*W-1:W];
      res_lo = prod[W-1:0];
    end else if (div_zero) begin
      res_hi = dividend;
      res_lo = '1;
    end else begin
      res_lo = neg_main ? (~raw_lo + 1'b1) : raw_lo;
      res_hi = neg_rem  ? (~raw_hi + 1'b1) : raw_hi;
    end
  end
endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         idle,
  input  logic         hi_we,
  input  logic [W-1:0] hi_wd,
  input  logic         lo_we,
  input  logic [W-1:0] lo_wd,
  input  logic         commit,
  input  logic [W-1:0] c_hi,
  input  logic [W-1:0] c_lo,
  output logic [W-1:0] hi_q,
  output logic [W-1:0] lo_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (commit) begin
      hi_q <= c_hi;
      lo_q <= c_lo;
    end else if (idle) begin
      if (hi_we) hi_q <= hi_wd;
      if (lo_we) lo_q <= lo_wd;
    end
  end
endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [1:0]   req_op,
  input  logic [W-1:0] req_a,
  input  logic [W-1:0] req_b,
  output logic         busy,
  output logic         done,
  input  logic         hi_wr_en,
  input  logic [W-1:0] hi_wr_data,
  input  logic         lo_wr_en,
  input  logic [W-1:0] lo_wr_data,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  logic         accept;
  logic [W-1:0] a_mag, b_mag;
  logic         p_div, p_dz, p_neg, p_nrem;
  logic         f_div, f_dz, f_neg, f_nrem;
  logic [W-1:0] f_a;
  logic         eng_busy, eng_fin;
  logic [W-1:0] raw_hi, raw_lo, res_hi, res_lo;
  logic         done_q;

  assign accept    = req_valid & ~eng_busy;
  assign req_ready = ~eng_busy;
  assign busy      = eng_busy;
  assign done      = done_q;

  mdu_prep #(.W(W)) i_prep (
    .op(req_op), .a(req_a), .b(req_b),
    .a_mag(a_mag), .b_mag(b_mag),
    .is_div(p_div), .div_zero(p_dz), .neg_main(p_neg), .neg_rem(p_nrem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      f_div  <= 1'b0;
      f_dz   <= 1'b0;
      f_neg  <= 1'b0;
      f_nrem <= 1'b0;
      f_a    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= eng_fin;
      if (accept) begin
        f_div  <= p_div;
        f_dz   <= p_dz;
        f_neg  <= p_neg;
        f_nrem <= p_nrem;
        f_a    <= req_a;
      end
    end
  end

  mdu_engine #(.W(W)) i_engine (
    .clk(clk), .rst(rst), .start(accept), .is_div(p_div),
    .a_mag(a_mag), .b_mag(b_mag),
    .busy(eng_busy), .fin(eng_fin), .raw_hi(raw_hi), .raw_lo(raw_lo)
  );

  mdu_fix #(.W(W)) i_fix (
    .is_div(f_div), .div_zero(f_dz), .neg_main(f_neg), .neg_rem(f_nrem),
    .dividend(f_a), .raw_hi(raw_hi), .raw_lo(raw_lo),
    .res_hi(res_hi), .res_lo(res_lo)
  );

  mdu_hilo #(.W(W)) i_hilo (
    .clk(clk), .rst(rst), .idle(~eng_busy),
    .hi_we(hi_wr_en), .hi_wd(hi_wr_data),
    .lo_we(lo_wr_en), .lo_wd(lo_wr_data),
    .commit(eng_fin), .c_hi(res_hi), .c_lo(res_lo),
    .hi_q(hi), .lo_q(lo)
  );
endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic         req_valid,
  input logic         req_ready,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo
);
  localparam int LAT = W + 1;
  localparam int BW  = $clog2(LAT + 1) + 1;

  logic [BW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) bcnt <= '0;
    else              bcnt <= bcnt + 1'b1;
  end

  // R1: clean state right after reset
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !done && req_ready && hi == '0 && lo == '0));

  // R7: done lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: done only directly after a busy period
  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R7: busy period length
  a_r7_busy_len: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (bcnt == BW'(LAT)));

  // R8: an accepted request starts a busy period
  a_r8_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> busy);

  // R9: HI and LO hold while busy except at completion
  a_r9_hold_busy: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && !done) |-> ($stable(hi) && $stable(lo)));
endmodule

bind hilo_muldiv mdu_checker #(.W(W)) i_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .done(done), .hi(hi), .lo(lo)
);

// File: tb/test_hilo_muldiv.sv
module test_hilo_muldiv;
  localparam int W = 64;
  localparam int NV = 14;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [1:0]   req_op = 2'b00;
  logic [W-1:0] req_a = '0, req_b = '0;
  logic         busy, done;
  logic         hi_wr_en = 1'b0, lo_wr_en = 1'b0;
  logic [W-1:0] hi_wr_data = '0, lo_wr_data = '0;
  logic [W-1:0] hi, lo;

  int total = 0;
  int bad   = 0;
  int done_seen = 0;

  always #2 clk = ~clk;

  always @(posedge clk) if (done) done_seen <= done_seen + 1;

  hilo_muldiv #(.W(W)) i_hilo_muldiv (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_a(req_a), .req_b(req_b), .busy(busy), .done(done),
    .hi_wr_en(hi_wr_en), .hi_wr_data(hi_wr_data),
    .lo_wr_en(lo_wr_en), .lo_wr_data(lo_wr_data), .hi(hi), .lo(lo)
  );

  localparam logic [1:0] V_OP [NV] = '{
    2'b00, 2'b00, 2'b00, 2'b01, 2'b01, 2'b01,
    2'b10, 2'b10, 2'b10, 2'b10, 2'b11, 2'b11, 2'b10, 2'b11};
  localparam logic [W-1:0] V_A [NV] = '{
    64'd7, 64'hFFFF_FFFF_FFFF_FFF9, 64'h8000_0000_0000_0000,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 64'd0,
    64'hFFFF_FFFF_FFFF_FFF9, 64'd7, 64'h8000_0000_0000_0000,
    64'hFEDC_BA98_7654_3210, 64'hFFFF_FFFF_FFFF_FFFF, 64'd100,
    64'hFFFF_FFFF_FFFF_FFF9, 64'd12345};
  localparam logic [W-1:0] V_B [NV] = '{
    64'hFFFF_FFFF_FFFF_FFFD, 64'hFFFF_FFFF_FFFF_FFFD, 64'h8000_0000_0000_0000,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h0FED_CBA9_8765_4321, 64'h5555_5555_5555_5555,
    64'd2, 64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF,
    64'd1000003, 64'd3, 64'd7, 64'd0, 64'd0};

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic model(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       output logic [W-1:0] eh, output logic [W-1:0] el);
    logic [2*W-1:0] p;
    logic signed [2*W-1:0] sx, sy;
    logic signed [W+1:0] dx, dy, dq, dr;
    case (op)
      2'b00: begin
        sx = {{W{a[W-1]}}, a}; sy = {{W{b[W-1]}}, b};
        p = sx * sy; eh = p[2*W-1:W]; el = p[W-1:0];
      end
      2'b01: begin
        p = {{W{1'b0}}, a} * {{W{1'b0}}, b}; eh = p[2*W-1:W]; el = p[W-1:0];
      end
      default: begin
        if (b == '0) begin
          eh = a; el = '1;
        end else if (op == 2'b10) begin
          dx = {{2{a[W-1]}}, a}; dy = {{2{b[W-1]}}, b};
          dq = dx / dy; dr = dx % dy;
          el = dq[W-1:0]; eh = dr[W-1:0];
        end else begin
          el = a / b; eh = a % b;
        end
      end
    endcase
  endtask

  // Issue one request; returns cycles from the drive edge to done visibility.
  task automatic run_op(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                        output int cyc);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_a = a; req_b = b;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  function automatic string tag_of(input logic [1:0] op, input logic [W-1:0] b);
    if (op[1] && b == '0) return "R6";
    case (op)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc;
    logic [W-1:0] eh, el;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 hi in reset", hi, '0);
    chk("R1 busy in reset", {63'd0, busy}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 lo after reset", lo, '0);
    chk("R1 ready after reset", {63'd0, req_ready}, 1);
    chk("R1 done after reset", {63'd0, done}, 0);

    for (int i = 0; i < NV; i++) begin
      run_op(V_OP[i], V_A[i], V_B[i], cyc);
      model(V_OP[i], V_A[i], V_B[i], eh, el);
      chk({tag_of(V_OP[i], V_B[i]), " hi"}, hi, eh);
      chk({tag_of(V_OP[i], V_B[i]), " lo"}, lo, el);
      if (i == 0) chk("R7 latency", 64'(cyc), 64'd66);
    end

    // R4 hand-computed: -7 / 2 -> q=-3, r=-1
    run_op(2'b10, 64'hFFFF_FFFF_FFFF_FFF9, 64'd2, cyc);
    chk("R4 trunc quotient", lo, 64'hFFFF_FFFF_FFFF_FFFD);
    chk("R4 remainder sign", hi, 64'hFFFF_FFFF_FFFF_FFFF);
    // R4 overflow case
    run_op(2'b10, 64'h8000_0000_0000_0000, '1, cyc);
    chk("R4 min/-1 lo", lo, 64'h8000_0000_0000_0000);
    chk("R4 min/-1 hi", hi, '0);
    // R6 hand-computed
    run_op(2'b11, 64'hDEAD_BEEF_0000_0001, '0, cyc);
    chk("R6 dz lo", lo, '1);
    chk("R6 dz hi", hi, 64'hDEAD_BEEF_0000_0001);

    // R7 busy timing and done pulse width
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'b01; req_a = 64'd3; req_b = 64'd5;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 busy after accept", {63'd0, busy}, 1);
    chk("R7 ready low when busy", {63'd0, req_ready}, 0);
    repeat (64) @(negedge clk);
    chk("R7 busy at 65th cycle", {63'd0, busy}, 1);
    chk("R7 done not early", {63'd0, done}, 0);
    @(negedge clk);
    chk("R7 done pulse", {63'd0, done}, 1);
    chk("R7 result lo", lo, 64'd15);
    @(negedge clk);
    chk("R7 done cleared", {63'd0, done}, 0);

    // R8 and R9: request and writes in mid-flight are ignored
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'b11; req_a = 64'd1000; req_b = 64'd7;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    done_seen = 0;
    req_valid = 1'b1; req_op = 2'b01; req_a = 64'd9; req_b = 64'd9;
    hi_wr_en = 1'b1; hi_wr_data = 64'hAAAA; lo_wr_en = 1'b1; lo_wr_data = 64'hBBBB;
    @(negedge clk);
    req_valid = 1'b0; hi_wr_en = 1'b0; lo_wr_en = 1'b0;
    chk("R9 hi write ignored busy", hi, 64'd15 >> 64);
    while (!done) @(negedge clk);
    chk("R8 inflight lo", lo, 64'd142);
    chk("R8 inflight hi", hi, 64'd6);
    repeat (80) @(negedge clk);
    chk("R8 single done", 64'(done_seen), 64'd1);
    chk("R8 idle after drop", {63'd0, busy}, 0);

    // R9 idle writes
    hi_wr_en = 1'b1; hi_wr_data = 64'h1111_2222_3333_4444;
    @(negedge clk);
    hi_wr_en = 1'b0;
    chk("R9 hi written", hi, 64'h1111_2222_3333_4444);
    chk("R9 lo untouched", lo, 64'd142);
    lo_wr_en = 1'b1; lo_wr_data = 64'h5555_6666_7777_8888;
    @(negedge clk);
    lo_wr_en = 1'b0;
    chk("R9 lo written", lo, 64'h5555_6666_7777_8888);

    // R10 write and accept in one idle cycle
    req_valid = 1'b1; req_op = 2'b00; req_a = 64'd6; req_b = 64'hFFFF_FFFF_FFFF_FFFF;
    hi_wr_en = 1'b1; hi_wr_data = 64'hCAFE;
    @(negedge clk);
    req_valid = 1'b0; hi_wr_en = 1'b0;
    chk("R10 write landed", hi, 64'hCAFE);
    while (!done) @(negedge clk);
    chk("R10 result hi", hi, '1);
    chk("R10 result lo", lo, 64'hFFFF_FFFF_FFFF_FFFA);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule